// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Peripheral Overrides

This block is an N-pin general-purpose I/O port. Each pin owns a direction bit, an output bit that doubles as the pull-up request while the pin is an input, and a two-flop synchronizer on the pad input. Software reaches the port through three shared write strobes and three shared read strobes on a common data word. The write strobes load the direction register, load the output register, or toggle output bits.

A peripheral can take over any pin piece by piece. Four enable/value pairs per pin replace the pull-up, the drive enable, the driven value and the input enable. A fifth per-pin enable toggles the output bit. A global sleep signal shuts off the input path of every pin unless its input-enable override holds it on. A global pull-up disable suppresses every pull-up that is not overridden. When a pin's input is disabled, its pad value is forced to 0 ahead of the synchronizer, so a floating pad cannot produce activity.

There is no state machine. The per-pin state is two register bits and the two synchronizer stages. Everything else is combinational selection between register values and override values.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction and output registers and both synchronizer stages are 0. With no overrides, `pad_oe`, `pad_out`, `pad_pu` and `periph_in` are therefore all 0.
- R2: On a clock edge with `dir_wr` high, the direction register takes `wdata`. On a clock edge with `out_wr` high, the output register takes `wdata`.
- R3: `pad_oe[i]` equals `ovr_dir_val[i]` when `ovr_dir_en[i]` is 1, and otherwise equals direction bit i (1 = drive).
- R4: `pad_out[i]` equals `ovr_out_val[i]` when `ovr_out_en[i]` is 1, and otherwise equals output bit i.
- R5: With `ovr_pu_en[i]` at 0, `pad_pu[i]` is 1 only when direction bit i is 0, output bit i is 1 and `pullup_dis` is 0. With `ovr_pu_en[i]` at 1, `pad_pu[i]` equals `ovr_pu_val[i]` whatever the value of `pullup_dis`.
- R6: On an edge without `out_wr`, output bit i inverts if `pin_wr` is high with `wdata[i]`=1, or if `ovr_tgl_en[i]` is 1. Both causes together give a single inversion. A `pin_wr` bit of 0 leaves the output bit unchanged. When `out_wr` is high on the same edge, the loaded `wdata` wins over any toggle.
- R7: The input of pin i is enabled by `ovr_ie_val[i]` when `ovr_ie_en[i]` is 1, and otherwise by `!sleep_en`. While the input is disabled, the value entering the synchronizer is 0.
- R8: `periph_in[i]` and the pin value seen on a pin read equal the gated pad value as it was sampled two clock edges earlier.
- R9: `rdata` gives the direction register when `dir_rd` is high. Otherwise it gives the output register when `out_rd` is high, otherwise the synchronized pins when `pin_rd` is high, and otherwise 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_wr | input | 1 | Load direction register from `wdata` |
| out_wr | input | 1 | Load output register from `wdata` |
| pin_wr | input | 1 | Toggle output bits where `wdata` is 1 |
| dir_rd | input | 1 | Select direction register onto `rdata` |
| out_rd | input | 1 | Select output register onto `rdata` |
| pin_rd | input | 1 | Select synchronized pins onto `rdata` |
| wdata | input | N | Write data |
| rdata | output | N | Read data |
| pullup_dis | input | 1 | Global pull-up disable |
| sleep_en | input | 1 | Global input shut-off |
| pad_in | input | N | Raw pad inputs |
| ovr_pu_en | input | N | Pull-up override enable |
| ovr_pu_val | input | N | Pull-up override value |
| ovr_dir_en | input | N | Drive-enable override enable |
| ovr_dir_val | input | N | Drive-enable override value |
| ovr_out_en | input | N | Output-value override enable |
| ovr_out_val | input | N | Output-value override value |
| ovr_ie_en | input | N | Input-enable override enable |
| ovr_ie_val | input | N | Input-enable override value |
| ovr_tgl_en | input | N | Output toggle request from peripheral |
| pad_out | output | N | Value driven to pad |
| pad_oe | output | N | Pad drive enable |
| pad_pu | output | N | Pad pull-up enable |
| periph_in | output | N | Synchronized, gated input for peripherals |

## Verification
The bench targets the collisions between register and override paths. One case is `out_wr` together with a pin-register toggle and a peripheral toggle on the same edge: a design with the wrong precedence would keep a toggled value instead of the loaded data. Another is both toggle causes together, where a design that XORs the two instead of ORing them would cancel them out. The input gating is driven with the pad held high during sleep, with the input-enable override turned on and off. A design that gates after the synchronizer, or that ignores the override, would show the wrong latency or keep reading 1 while asleep. Random traffic with several read strobes at once checks the read priority, and toggling `pullup_dis` under a pull-up override checks that the override wins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic en;
        logic val;
    } ovr_pair_t;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_DIR  = 2'd1,
        RD_OUT  = 2'd2,
        RD_PIN  = 2'd3
    } rd_src_e;

    function automatic logic apply_ovr(input ovr_pair_t p, input logic normal);
        return p.en ? p.val : normal;
    endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [SYNC_DEPTH-1:0] stage_q;

    generate
        for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= 1'b0;
                    else        stage_q[s] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= 1'b0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[SYNC_DEPTH-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dir_wr,
    input  logic      out_wr,
    input  logic      pin_wr,
    input  logic      wbit,
    input  logic      pullup_dis,
    input  logic      sleep_en,
    input  logic      pad_in,
    input  ovr_pair_t ovr_pu,
    input  ovr_pair_t ovr_dir,
    input  ovr_pair_t ovr_out,
    input  ovr_pair_t ovr_ie,
    input  logic      ovr_tgl_en,
    output logic      pad_out,
    output logic      pad_oe,
    output logic      pad_pu,
    output logic      periph_in,
    output logic      dir_bit,
    output logic      out_bit
);
    logic dir_q;
    logic out_q;
    logic tgl_req;
    logic in_en;
    logic pad_gated;
    logic pu_normal;

    // Register path
    assign tgl_req = (pin_wr & wbit) | ovr_tgl_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
        end else if (dir_wr) begin
            dir_q <= wbit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (out_wr) begin
            out_q <= wbit;
        end else if (tgl_req) begin
            out_q <= ~out_q;
        end
    end

    // Override selection
    assign pu_normal = ~dir_q & out_q & ~pullup_dis;
    assign pad_pu    = apply_ovr(ovr_pu, pu_normal);
    assign pad_oe    = apply_ovr(ovr_dir, dir_q);
    assign pad_out   = apply_ovr(ovr_out, out_q);
    assign in_en     = apply_ovr(ovr_ie, ~sleep_en);
    assign pad_gated = pad_in & in_en;

    gpio_sync_chain u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_gated),
        .q     (periph_in)
    );

    assign dir_bit = dir_q;
    assign out_bit = out_q;

    // Warm-up counter so the latency check only looks back over post-reset edges
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (dir_q == $past(wbit)));

    // R6
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_wr && tgl_req) |=> (out_q != $past(out_q)));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_wr && !tgl_req) |=> $stable(out_q));

    // R5
    pud_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_pu.en && pullup_dis) |-> !pad_pu);

    // R8
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (periph_in == $past(pad_gated, 2)));

    // R7
    ie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_en && !pad_gated) || in_en);
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_rd,
    input  logic         out_rd,
    input  logic         pin_rd,
    input  logic [N-1:0] dir_v,
    input  logic [N-1:0] out_v,
    input  logic [N-1:0] pin_v,
    output logic [N-1:0] rdata
);
    rd_src_e src;

    always_comb begin
        if (dir_rd)      src = RD_DIR;
        else if (out_rd) src = RD_OUT;
        else if (pin_rd) src = RD_PIN;
        else             src = RD_NONE;
    end

    always_comb begin
        unique case (src)
            RD_DIR:  rdata = dir_v;
            RD_OUT:  rdata = out_v;
            RD_PIN:  rdata = pin_v;
            default: rdata = '0;
        endcase
    end

    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_rd && !out_rd && !pin_rd) |-> (rdata == '0));

    // R9
    rd_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rd && !dir_rd && !out_rd) |-> (rdata == pin_v));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_wr,
    input  logic         out_wr,
    input  logic         pin_wr,
    input  logic         dir_rd,
    input  logic         out_rd,
    input  logic         pin_rd,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] rdata,
    input  logic         pullup_dis,
    input  logic         sleep_en,
    input  logic [N-1:0] pad_in,
    input  logic [N-1:0] ovr_pu_en,
    input  logic [N-1:0] ovr_pu_val,
    input  logic [N-1:0] ovr_dir_en,
    input  logic [N-1:0] ovr_dir_val,
    input  logic [N-1:0] ovr_out_en,
    input  logic [N-1:0] ovr_out_val,
    input  logic [N-1:0] ovr_ie_en,
    input  logic [N-1:0] ovr_ie_val,
    input  logic [N-1:0] ovr_tgl_en,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe,
    output logic [N-1:0] pad_pu,
    output logic [N-1:0] periph_in
);
    logic [N-1:0] dir_v;
    logic [N-1:0] out_v;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            ovr_pair_t pu_p, dir_p, out_p, ie_p;
            assign pu_p  = '{en: ovr_pu_en[i],  val: ovr_pu_val[i]};
            assign dir_p = '{en: ovr_dir_en[i], val: ovr_dir_val[i]};
            assign out_p = '{en: ovr_out_en[i], val: ovr_out_val[i]};
            assign ie_p  = '{en: ovr_ie_en[i],  val: ovr_ie_val[i]};

            gpio_pin_cell u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .dir_wr     (dir_wr),
                .out_wr     (out_wr),
                .pin_wr     (pin_wr),
                .wbit       (wdata[i]),
                .pullup_dis (pullup_dis),
                .sleep_en   (sleep_en),
                .pad_in     (pad_in[i]),
                .ovr_pu     (pu_p),
                .ovr_dir    (dir_p),
                .ovr_out    (out_p),
                .ovr_ie     (ie_p),
                .ovr_tgl_en (ovr_tgl_en[i]),
                .pad_out    (pad_out[i]),
                .pad_oe     (pad_oe[i]),
                .pad_pu     (pad_pu[i]),
                .periph_in  (periph_in[i]),
                .dir_bit    (dir_v[i]),
                .out_bit    (out_v[i])
            );
        end
    endgenerate

    gpio_read_mux #(.N(N)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_rd (dir_rd),
        .out_rd (out_rd),
        .pin_rd (pin_rd),
        .dir_v  (dir_v),
        .out_v  (out_v),
        .pin_v  (periph_in),
        .rdata  (rdata)
    );

    // R3
    oe_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovr_dir_en & (pad_oe ^ ovr_dir_val)) == '0));

    // R4
    out_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovr_out_en & (pad_out ^ ovr_out_val)) == '0));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    localparam int N = 8;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_wr = 0, out_wr = 0, pin_wr = 0, dir_rd = 0, out_rd = 0, pin_rd = 0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic pullup_dis = 0, sleep_en = 0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] ovr_pu_en = '0, ovr_pu_val = '0, ovr_dir_en = '0, ovr_dir_val = '0;
    logic [N-1:0] ovr_out_en = '0, ovr_out_val = '0, ovr_ie_en = '0, ovr_ie_val = '0;
    logic [N-1:0] ovr_tgl_en = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pu, periph_in;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [N-1:0] dir_m = '0, out_m = '0, s1_m = '0, s2_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port #(.N(N)) u_gpio_port (.*);

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] exp_ie();
        return (ovr_ie_en & ovr_ie_val) | (~ovr_ie_en & {N{~sleep_en}});
    endfunction

    function automatic logic [N-1:0] exp_pu();
        return (ovr_pu_en & ovr_pu_val) |
               (~ovr_pu_en & ~dir_m & out_m & {N{~pullup_dis}});
    endfunction

    function automatic logic [N-1:0] exp_rd();
        if (dir_rd) return dir_m;
        if (out_rd) return out_m;
        if (pin_rd) return s2_m;
        return '0;
    endfunction

    // Called just after a negedge with inputs set; checks, then advances one edge.
    task automatic step();
        logic [N-1:0] nd, no, ns1;
        #1;
        chk("R3 pad_oe", pad_oe, (ovr_dir_en & ovr_dir_val) | (~ovr_dir_en & dir_m));
        chk("R4 pad_out", pad_out, (ovr_out_en & ovr_out_val) | (~ovr_out_en & out_m));
        chk("R5 pad_pu", pad_pu, exp_pu());
        chk("R8 periph_in", periph_in, s2_m);
        chk("R9 rdata", rdata, exp_rd());
        nd  = dir_wr ? wdata : dir_m;
        no  = out_wr ? wdata : (out_m ^ ((pin_wr ? wdata : '0) | ovr_tgl_en));
        ns1 = pad_in & exp_ie();
        @(posedge clk);
        s2_m = s1_m; s1_m = ns1; dir_m = nd; out_m = no;
        @(negedge clk);
    endtask

    task automatic idle();
        dir_wr = 0; out_wr = 0; pin_wr = 0; dir_rd = 0; out_rd = 0; pin_rd = 0;
        ovr_tgl_en = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        dir_rd = 1; #1;
        chk("R1 dir after reset", rdata, '0);
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        chk("R1 pad_pu", pad_pu, '0);
        chk("R1 periph_in", periph_in, '0);
        idle();

        // R2 direction and output loads
        wdata = 8'hA5; dir_wr = 1; step(); idle();
        dir_rd = 1; #1; chk("R2 dir load", rdata, 8'hA5); idle();
        wdata = 8'h0F; out_wr = 1; step(); idle();
        out_rd = 1; #1; chk("R2 out load", rdata, 8'h0F); idle();

        // R6 pin write toggles ones only
        wdata = 8'h3C; pin_wr = 1; step(); idle();
        out_rd = 1; #1; chk("R6 pin_wr toggle", rdata, 8'h33); idle();
        // R6 both causes on the same bit: single inversion
        wdata = 8'h01; pin_wr = 1; ovr_tgl_en = 8'h81; step(); idle();
        out_rd = 1; #1; chk("R6 double cause", rdata, 8'hB2); idle();
        // R6 out_wr beats toggles
        wdata = 8'h55; out_wr = 1; ovr_tgl_en = 8'hFF; step(); idle();
        out_rd = 1; #1; chk("R6 load priority", rdata, 8'h55); idle();

        // R7 sleep gates pad to 0
        pad_in = 8'hFF; sleep_en = 1; step(); step(); step();
        pin_rd = 1; #1; chk("R7 sleep gated", rdata, 8'h00); idle();
        // R8 override forces input on; visible after two edges
        ovr_ie_en = 8'h0F; ovr_ie_val = 8'h0F; step();
        #1; chk("R8 one edge", periph_in, 8'h00);
        step();
        #1; chk("R8 two edges", periph_in, 8'h0F);
        ovr_ie_val = 8'h00; step(); step();
        #1; chk("R7 override off", periph_in, 8'h00);
        ovr_ie_en = '0; sleep_en = 0;

        // R5 override wins over pullup_dis
        pullup_dis = 1; ovr_pu_en = 8'hF0; ovr_pu_val = 8'hA0; #1;
        chk("R5 pu override", pad_pu, 8'hA0);
        ovr_pu_en = '0; #1;
        chk("R5 pud blocks", pad_pu, 8'h00);
        pullup_dis = 0; step();

        // Random traffic
        for (int c = 0; c < RAND_CYCLES; c++) begin
            dir_wr = ($urandom % 6) == 0;
            out_wr = ($urandom % 5) == 0;
            pin_wr = ($urandom % 4) == 0;
            dir_rd = ($urandom % 4) == 0;
            out_rd = ($urandom % 3) == 0;
            pin_rd = ($urandom % 2) == 0;
            wdata = N'($urandom);
            pullup_dis = ($urandom % 4) == 0;
            sleep_en = ($urandom % 3) == 0;
            pad_in = N'($urandom);
            ovr_pu_en = N'($urandom) & N'($urandom);
            ovr_pu_val = N'($urandom);
            ovr_dir_en = N'($urandom) & N'($urandom);
            ovr_dir_val = N'($urandom);
            ovr_out_en = N'($urandom) & N'($urandom);
            ovr_out_val = N'($urandom);
            ovr_ie_en = N'($urandom) & N'($urandom);
            ovr_ie_val = N'($urandom);
            ovr_tgl_en = N'($urandom) & N'($urandom) & N'($urandom);
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule